// File: doc/BRIEF.md
# Scan Pattern Don't-Care Filler

This block turns a partially specified scan test pattern into a fully specified bit stream ready to be shifted into a scan chain. Each incoming position carries a value and a flag that says whether the position is a care bit or a don't-care. Care bits leave the block untouched. Don't-cares are resolved by one of four policies: constant zero, constant one, a pseudorandom bit, or a copy of the neighbouring care bit. The last policy keeps long runs of equal values in the chain, which cuts shift transitions and so shift power.

Positions stream in one per cycle in scan order over a valid/ready input. The filled bits leave one per cycle over a valid/ready output whose register sits at the block's edge. A flag marks the final position of each pattern. In adjacent mode, don't-cares at the head of a pattern come before any care bit. The block therefore only counts them until the first care bit shows up, and then releases the whole run at once. A 16-bit maximal-length shift register supplies the random bits, and it can be reseeded through a load strobe.

Top module: `scan_xfill`

## Requirements
- R1: A position with `in_care`=1 leaves with its `in_bit` value unchanged in every mode, and output order equals input order.
- R2: With mode code 0, every don't-care leaves as 0.
- R3: With mode code 1, every don't-care leaves as 1.
- R4: With mode code 2, each don't-care leaves as bit 0 of the random state. The state then moves one step: it shifts right by one, and the XOR of bits 0, 2, 3 and 5 enters bit 15. It steps only on random-mode don't-cares. After reset the state is 16'hACE1.
- R5: A high `seed_load` at a clock edge sets the random state to `seed_value`, or to 16'hACE1 when `seed_value` is zero. If a random don't-care is accepted at that same edge, it still uses the bit of the old state, and the load wins over the step.
- R6: With mode code 3, a don't-care takes the value of the latest care bit before it in the same pattern (0XXX1XX in scan order gives 0000111).
- R7: With mode code 3, don't-cares before the first care bit of a pattern take that care bit's value. `in_ready` stays low while the held run is released. The head run must be shorter than MAX_LEN.
- R8: With mode code 3, a pattern with no care bit at all leaves as all zeros.
- R9: `in_last` marks the final position of a pattern. `out_last` is high on exactly the matching output position. The adjacent-fill history never crosses a pattern boundary.
- R10: The mode is taken on the first position of a pattern and held until its last position. Changes on `mode` during a pattern have no effect.
- R11: While `out_valid` is high and `out_ready` is low, `out_bit` and `out_last` hold and no position is lost or duplicated.
- R12: In the cycle after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Fill policy: 0 zero, 1 one, 2 random, 3 adjacent |
| seed_load | input | 1 | Load strobe for the random state |
| seed_value | input | 16 | New random state (zero maps to 16'hACE1) |
| in_valid | input | 1 | Input position valid |
| in_ready | output | 1 | Block accepts a position this cycle |
| in_care | input | 1 | 1 = care bit, 0 = don't-care |
| in_bit | input | 1 | Care value (ignored for don't-cares) |
| in_last | input | 1 | Final position of the pattern |
| out_valid | output | 1 | Output position valid |
| out_ready | input | 1 | Consumer accepts the output position |
| out_bit | output | 1 | Filled bit |
| out_last | output | 1 | Final filled position of the pattern |

## Verification
A reseed and a random-mode step can fall on the same clock edge. The bench raises `seed_load` for exactly the edge that accepts a random don't-care, with the output unthrottled so the accept edge is known. It expects that position to carry the old state's bit, and every later don't-care to follow the new seed. The release of a held head run in adjacent mode can also meet output backpressure. Patterns are sent back to back while `out_ready` is throttled, and the scoreboard checks the order, the values and the placement of the last flag.

// File: rtl/xfill_pkg.sv
package xfill_pkg;
  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_ONE  = 2'd1,
    FILL_RAND = 2'd2,
    FILL_ADJ  = 2'd3
  } fill_mode_e;

  localparam int          RND_W       = 16;
  localparam logic [15:0] RND_TAPS    = 16'h002D;
  localparam logic [15:0] RND_DEFAULT = 16'hACE1;
endpackage

// File: rtl/xfill_lfsr.sv
module xfill_lfsr #(
  parameter int             W        = 16,
  parameter logic [W-1:0]   TAP_MASK = 16'h002D,
  parameter logic [W-1:0]   DEFAULT  = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         feedback;

  assign feedback = ^(state_q & TAP_MASK);
  assign state_o  = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DEFAULT;
    end else if (load_i) begin
      state_q <= (seed_i == '0) ? DEFAULT : seed_i;
    end else if (step_i) begin
      state_q <= {feedback, state_q[W-1:1]};
    end
  end
endmodule

// File: rtl/xfill_resolve.sv
module xfill_resolve
  import xfill_pkg::*;
(
  input  fill_mode_e mode_i,
  input  logic       ref_bit_i,
  input  logic       rnd_bit_i,
  output logic       fill_o
);
  always_comb begin
    unique case (mode_i)
      FILL_ZERO: fill_o = 1'b0;
      FILL_ONE:  fill_o = 1'b1;
      FILL_RAND: fill_o = rnd_bit_i;
      FILL_ADJ:  fill_o = ref_bit_i;
      default:   fill_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xfill_outreg.sv
module xfill_outreg (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic bit_i,
  input  logic last_i,
  input  logic ready_i,
  output logic valid_o,
  output logic bit_o,
  output logic last_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      bit_o   <= 1'b0;
      last_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      bit_o   <= bit_i;
      last_o  <= last_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_xfill.sv
module scan_xfill
  import xfill_pkg::*;
#(
  parameter int MAX_LEN = 4096,
  parameter int SEED_W  = RND_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              seed_load,
  input  logic [SEED_W-1:0] seed_value,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_care,
  input  logic              in_bit,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit,
  output logic              out_last
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              slot_free, fire;
  logic              draining;
  logic              in_pat;
  fill_mode_e        mode_q, eff_mode;
  logic              ref_valid, ref_bit;
  logic [CNT_W-1:0]  pend_cnt;
  logic              drain_fill, held_valid, held_bit, held_last;
  logic              lead_x, lead_end;
  logic              x_bit;
  logic              emit, emit_bit, emit_last, lfsr_step;
  logic [SEED_W-1:0] lfsr_state;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = !draining && slot_free;
  assign fire      = in_valid && in_ready;
  assign eff_mode  = in_pat ? mode_q : fill_mode_e'(mode);
  assign lead_x    = (eff_mode == FILL_ADJ) && !ref_valid && !in_care;
  assign lead_end  = (eff_mode == FILL_ADJ) && in_care && (pend_cnt != '0);

  xfill_lfsr #(
    .W        (SEED_W),
    .TAP_MASK (SEED_W'(RND_TAPS)),
    .DEFAULT  (SEED_W'(RND_DEFAULT))
  ) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .load_i  (seed_load),
    .seed_i  (seed_value),
    .step_i  (lfsr_step),
    .state_o (lfsr_state)
  );

  xfill_resolve u_resolve (
    .mode_i    (eff_mode),
    .ref_bit_i (ref_bit),
    .rnd_bit_i (lfsr_state[0]),
    .fill_o    (x_bit)
  );

  xfill_outreg u_out (
    .clk     (clk),
    .rst     (rst),
    .load_i  (emit),
    .bit_i   (emit_bit),
    .last_i  (emit_last),
    .ready_i (out_ready),
    .valid_o (out_valid),
    .bit_o   (out_bit),
    .last_o  (out_last)
  );

  always_comb begin
    emit      = 1'b0;
    emit_bit  = 1'b0;
    emit_last = 1'b0;
    lfsr_step = 1'b0;
    if (draining) begin
      if (slot_free) begin
        emit = 1'b1;
        if (pend_cnt != '0) begin
          emit_bit  = drain_fill;
          emit_last = !held_valid && (pend_cnt == CNT_ONE);
        end else begin
          emit_bit  = held_bit;
          emit_last = held_last;
        end
      end
    end else if (fire && !lead_x && !lead_end) begin
      emit      = 1'b1;
      emit_bit  = in_care ? in_bit : x_bit;
      emit_last = in_last;
      lfsr_step = !in_care && (eff_mode == FILL_RAND);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      draining   <= 1'b0;
      in_pat     <= 1'b0;
      mode_q     <= FILL_ZERO;
      ref_valid  <= 1'b0;
      ref_bit    <= 1'b0;
      pend_cnt   <= '0;
      drain_fill <= 1'b0;
      held_valid <= 1'b0;
      held_bit   <= 1'b0;
      held_last  <= 1'b0;
    end else if (draining) begin
      if (slot_free) begin
        if (pend_cnt != '0) begin
          pend_cnt <= pend_cnt - CNT_ONE;
          if (pend_cnt == CNT_ONE && !held_valid) draining <= 1'b0;
        end else begin
          draining   <= 1'b0;
          held_valid <= 1'b0;
        end
      end
    end else if (fire) begin
      if (in_last) begin
        in_pat    <= 1'b0;
        ref_valid <= 1'b0;
      end else begin
        in_pat <= 1'b1;
        mode_q <= eff_mode;
        if (in_care) begin
          ref_valid <= 1'b1;
          ref_bit   <= in_bit;
        end
      end
      if (lead_x) begin
        pend_cnt <= pend_cnt + CNT_ONE;
        if (in_last) begin
          draining   <= 1'b1;
          drain_fill <= 1'b0;
          held_valid <= 1'b0;
        end
      end else if (lead_end) begin
        draining   <= 1'b1;
        drain_fill <= in_bit;
        held_valid <= 1'b1;
        held_bit   <= in_bit;
        held_last  <= in_last;
      end
    end
  end
endmodule

// File: rtl/scan_xfill_chk.sv
module scan_xfill_chk #(
  parameter int CNT_W  = 13,
  parameter int SEED_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              fire,
  input logic              in_care,
  input logic              in_bit,
  input logic              in_last,
  input logic              in_ready,
  input logic [1:0]        eff_mode,
  input logic [CNT_W-1:0]  pend_cnt,
  input logic              seed_load,
  input logic [SEED_W-1:0] seed_value,
  input logic [SEED_W-1:0] lfsr_state,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_bit,
  input logic              out_last
);
  AST_CARE_PASS: assert property (@(posedge clk) disable iff (rst)
    fire && in_care && (pend_cnt == '0) |=> out_valid && (out_bit == $past(in_bit)) && (out_last == $past(in_last))); // R1

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    fire && !in_care && (eff_mode == 2'd0) |=> out_valid && !out_bit); // R2

  AST_ONE_FILL: assert property (@(posedge clk) disable iff (rst)
    fire && !in_care && (eff_mode == 2'd1) |=> out_valid && out_bit); // R3

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> lfsr_state == (($past(seed_value) == '0) ? SEED_W'(16'hACE1) : $past(seed_value))); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_last)); // R11

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready); // R12
endmodule

bind scan_xfill scan_xfill_chk #(
  .CNT_W  (CNT_W),
  .SEED_W (SEED_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fire       (fire),
  .in_care    (in_care),
  .in_bit     (in_bit),
  .in_last    (in_last),
  .in_ready   (in_ready),
  .eff_mode   (eff_mode),
  .pend_cnt   (pend_cnt),
  .seed_load  (seed_load),
  .seed_value (seed_value),
  .lfsr_state (lfsr_state),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_bit    (out_bit),
  .out_last   (out_last)
);

// File: tb/scan_xfill_tb.sv
module scan_xfill_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic        seed_load = 1'b0;
  logic [15:0] seed_value = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_care = 1'b0;
  logic        in_bit = 1'b0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_bit;
  logic        out_last;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  logic [15:0] m_lfsr = 16'hACE1;

  always #10 clk = ~clk;

  scan_xfill u_dut (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_care    (in_care),
    .in_bit     (in_bit),
    .in_last    (in_last),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_bit    (out_bit),
    .out_last   (out_last)
  );

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {bit,last} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Scoreboard monitor: sets out_ready, then checks each transfer
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = bp_en ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (!rst && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL R1: extra output actual=%b expected=none", {out_bit, out_last});
        end else begin
          check(tag_q.pop_front(), {out_bit, out_last}, exp_q.pop_front());
        end
      end
    end
  end

  // Driver: computes expected filled pattern, queues it, then streams it in
  task automatic send(input string tag, input int n, input logic [31:0] cmask,
                      input logic [31:0] vals, input logic [1:0] md,
                      input logic [1:0] md_later, input int seed_at,
                      input logic [15:0] seedv);
    logic rv;
    bit   seen;
    rv   = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic e;
      if (cmask[i]) begin
        e = vals[i]; rv = vals[i]; seen = 1'b1;
      end else begin
        case (md)
          2'd0: e = 1'b0;
          2'd1: e = 1'b1;
          2'd2: begin e = m_lfsr[0]; m_lfsr = lfsr_next(m_lfsr); end
          default: begin
            if (seen) e = rv;
            else begin
              e = 1'b0;
              for (int j = n - 1; j > i; j--) if (cmask[j]) e = vals[j];
            end
          end
        endcase
      end
      if (i == seed_at) m_lfsr = (seedv == 16'h0) ? 16'hACE1 : seedv;
      exp_q.push_back({e, i == n - 1});
      tag_q.push_back(tag);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_care    = cmask[i];
      in_bit     = vals[i];
      in_last    = (i == n - 1);
      mode       = (i == 0) ? md : md_later;
      seed_load  = (i == seed_at);
      seed_value = seedv;
      #2;
      while (!in_ready) begin
        @(negedge clk);
        #2;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid  = 1'b0;
    seed_load = 1'b0;
  endtask

  task automatic drain_wait();
    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R12: out_valid/in_ready actual=%b%b expected=01", out_valid, in_ready);
    end

    // R2 zero fill, R1 care bits kept
    send("R2", 8, 32'b1001_0010, 32'b1000_0010, 2'd0, 2'd0, -1, 16'h0);
    // R3 one fill
    send("R3", 8, 32'b0110_0001, 32'b0100_0000, 2'd1, 2'd1, -1, 16'h0);
    // R6 adjacent: 0XXX1XX -> 0000111
    send("R6", 7, 32'b001_0001, 32'b001_0000, 2'd3, 2'd3, -1, 16'h0);
    // R7 leading run takes first care value: XXX1X0X -> 1111100
    send("R7", 7, 32'b010_1000, 32'b000_1000, 2'd3, 2'd3, -1, 16'h0);
    // R8 all don't-care adjacent -> zeros
    send("R8", 5, 32'h0, 32'h1F, 2'd3, 2'd3, -1, 16'h0);
    // R4 random fill from reset state
    send("R4", 12, 32'b0000_1000_0100, 32'b0000_1000_0000, 2'd2, 2'd2, -1, 16'h0);
    // R5 reseed on the same edge as a random step
    send("R5", 10, 32'b00_0000_0001, 32'h0, 2'd2, 2'd2, 3, 16'h1234);
    // R5 zero seed maps to the default state
    drain_wait();
    @(negedge clk);
    seed_value = 16'h0;
    seed_load  = 1'b1;
    @(negedge clk);
    seed_load  = 1'b0;
    m_lfsr     = 16'hACE1;
    send("R5", 6, 32'h0, 32'h0, 2'd2, 2'd2, -1, 16'h0);
    // R10 mode changes mid-pattern are ignored
    send("R10", 6, 32'b00_0100, 32'b00_0000, 2'd1, 2'd0, -1, 16'h0);
    drain_wait();
    // R9, R11 back-to-back adjacent patterns under backpressure
    bp_en = 1'b1;
    send("R9", 5, 32'b1_0010, 32'b1_0010, 2'd3, 2'd3, -1, 16'h0);
    send("R9", 6, 32'b01_0100, 32'b00_0000, 2'd3, 2'd3, -1, 16'h0);
    send("R11", 4, 32'b1000, 32'b1000, 2'd3, 2'd3, -1, 16'h0);
    send("R11", 6, 32'b10_0101, 32'b00_0100, 2'd0, 2'd0, -1, 16'h0);
    drain_wait();
    bp_en = 1'b0;
    repeat (5) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R9: outputs missing actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    report();
  end
endmodule